// File: doc/BRIEF.md
# Two-Thread Partitioned Reorder Buffer

This block follows the in-flight instructions of two hardware threads so that each thread retires strictly in its own program order. The entry array is cut into two equal halves, one per thread. Each half is run as a ring with its own head and tail. A thread that is slow or stalled can fill only its own half, so it never holds back dispatch or retirement of the other thread.

The rename stage dispatches one instruction per cycle. It names the thread and gives the new and the previous physical destination tags, and it receives the entry index that the instruction took. If that thread's half has no room, it receives a full indication instead. Execution units report completion by entry index, in any order. Each cycle, every thread can retire its oldest instruction once that instruction is done, including in the very cycle its completion arrives. On retirement the block presents the previous tag, to be released to the free list, and the new tag. A per-thread flush discards one thread's instructions. A single-thread mode hands the whole array to thread 0.

Top module: `rob_partitioned`

## Requirements
- R1: After reset no thread retires, neither thread reports full, and the first dispatch of thread 0 gets index 0 while the first dispatch of thread 1 gets index DEPTH/2.
- R2: In split mode thread 0 dispatches into indices 0..DEPTH/2-1 and thread 1 into DEPTH/2..DEPTH-1. Each thread takes consecutive indices and wraps back to the start of its own half.
- R3: `disp_full` reflects only the slice of the thread named by `disp_tid`. It is 1 when that slice holds DEPTH/2 instructions that have not retired. A dispatch made while full is dropped and never retires.
- R4: Within a thread, instructions retire in dispatch order. An instruction that completes early is held until every older instruction of its thread has retired.
- R5: An instruction at the head of its thread retires in the same cycle its completion is presented on `cmp_valid`/`cmp_idx`.
- R6: An incomplete head in one thread does not prevent the other thread from retiring.
- R7: Each thread retires at most one instruction per cycle. Its `cmt_old_tag` and `cmt_new_tag` lanes (lane 0 = thread 0, lane 1 = thread 1) equal the tags given at that instruction's dispatch.
- R8: With `solo_mode` = 1, thread 0 uses indices 0..DEPTH-1 as a single ring of DEPTH entries. Thread 1 always reports full and never retires.
- R9: `flush[t]` = 1 discards all of thread t's instructions, suppresses its retirement in that cycle, and resets its ring so that its next index is the base of its slice. The other thread is unaffected.
- R10: A completion for an index that holds no in-flight instruction is ignored. An instruction dispatched into that index later still waits for its own completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| solo_mode | input | 1 | 1: thread 0 owns the whole array |
| disp_valid | input | 1 | Dispatch request |
| disp_tid | input | 1 | Thread of the dispatch |
| disp_old_tag | input | TAG_W | Previous physical tag of the destination |
| disp_new_tag | input | TAG_W | Newly allocated physical tag |
| disp_full | output | 1 | Slice of `disp_tid` has no free entry |
| disp_idx | output | $clog2(DEPTH) | Entry index given to the dispatch |
| cmp_valid | input | 1 | Completion report |
| cmp_idx | input | $clog2(DEPTH) | Index of the completed entry |
| flush | input | 2 | Per-thread discard, bit t for thread t |
| cmt_valid | output | 2 | Thread t retires this cycle |
| cmt_old_tag | output | 2 x TAG_W | Tag to release, per thread |
| cmt_new_tag | output | 2 x TAG_W | Tag that becomes architectural, per thread |

## Verification
The hardest situation to reach is a completion that lands on a thread's head while younger entries of that thread are already done. The retirement in that cycle must happen at once, and the younger entries must then drain one per cycle. Random completions that are picked from the model's own in-flight lists produce this often. A directed sequence forces it and also covers the related cases: a completion that arrives before the entry exists, a flush of one thread while the other thread's head is pending, and a slice that wraps while it is full.

// File: rtl/rob_pkg.sv
// Shared definitions for the partitioned reorder buffer.
// Assumes exactly two hardware threads.
package rob_pkg;
    localparam int unsigned THREADS = 2;
    typedef logic [THREADS-1:0] thr_mask_t;
endpackage

// File: rtl/rob_ring_ctrl.sv
// Head/tail control for one thread's slice. Offsets are local to the slice,
// and a wrap bit on each pointer tells full from empty. Capacity is an input
// so the same ring can span half or all of the array.
// Assumes: the caller never pushes when full or pops when empty, and cap
// changes only while the ring is empty.
module rob_ring_ctrl #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W:0]   cap,
    input  logic             push,
    input  logic             pop,
    input  logic             clear,
    output logic [IDX_W-1:0] head_off,
    output logic [IDX_W-1:0] tail_off,
    output logic             full,
    output logic             empty
);
    logic head_wrap, tail_wrap;
    logic head_end, tail_end;
    logic [IDX_W:0] occ;

    // Detect the last offset of the slice for wrap-around.
    assign head_end = ({1'b0, head_off} == cap - 1'b1);
    assign tail_end = ({1'b0, tail_off} == cap - 1'b1);

    // Move the pointers on push/pop; clear and reset empty the ring.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            head_off  <= '0;
            tail_off  <= '0;
            head_wrap <= 1'b0;
            tail_wrap <= 1'b0;
        end else begin
            if (push) begin
                tail_off  <= tail_end ? '0 : tail_off + 1'b1;
                tail_wrap <= tail_wrap ^ tail_end;
            end
            if (pop) begin
                head_off  <= head_end ? '0 : head_off + 1'b1;
                head_wrap <= head_wrap ^ head_end;
            end
        end
    end

    // Equal offsets mean empty or full; the wrap bits decide which.
    assign empty = (head_off == tail_off) && (head_wrap == tail_wrap);
    assign full  = (head_off == tail_off) && (head_wrap != tail_wrap);

    // Occupancy, used only by the checks below.
    assign occ = (head_wrap == tail_wrap) ? ({1'b0, tail_off} - {1'b0, head_off})
                                          : (cap - {1'b0, head_off} + {1'b0, tail_off});

    assert_no_push_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_pop_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= cap);
    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> empty);
endmodule

// File: rtl/rob_entry_store.sv
// Entry storage: a done flag and two tags per entry, one write port for
// dispatch, one set port for completion, one read port per thread head.
// Assumes: when dispatch and completion hit the same index in one cycle,
// the dispatch wins (the entry starts not done).
module rob_entry_store #(
    parameter int DEPTH = 16,
    parameter int TAG_W = 6,
    parameter int IDX_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [TAG_W-1:0]            wr_old,
    input  logic [TAG_W-1:0]            wr_new,
    input  logic                        cmp_en,
    input  logic [IDX_W-1:0]            cmp_idx,
    input  logic [1:0][IDX_W-1:0]       rd_idx,
    output logic [1:0]                  rd_done,
    output logic [1:0][TAG_W-1:0]       rd_old,
    output logic [1:0][TAG_W-1:0]       rd_new
);
    logic [DEPTH-1:0] done_q;
    logic [TAG_W-1:0] old_q [DEPTH];
    logic [TAG_W-1:0] new_q [DEPTH];

    // Done flags: set on completion, cleared when an entry is reused.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= '0;
        end else begin
            if (cmp_en) done_q[cmp_idx] <= 1'b1;
            if (wr_en)  done_q[wr_idx]  <= 1'b0;
        end
    end

    // Tag storage written at dispatch.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            old_q[wr_idx] <= wr_old;
            new_q[wr_idx] <= wr_new;
        end
    end

    // Head read ports, one per thread.
    for (genvar t = 0; t < 2; t++) begin : g_rd
        assign rd_done[t] = done_q[rd_idx[t]];
        assign rd_old[t]  = old_q[rd_idx[t]];
        assign rd_new[t]  = new_q[rd_idx[t]];
    end
endmodule

// File: rtl/rob_partitioned.sv
// Two-thread reorder buffer with a static half/half split of the entries.
// Each thread retires in order from its own ring, at most one per cycle,
// and may retire an entry in the cycle its completion arrives.
// Assumes: DEPTH is a power of two >= 4; solo_mode changes only while both
// rings are empty; completions name indices handed out by dispatch.
module rob_partitioned #(
    parameter int DEPTH = 16,
    parameter int TAG_W = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       solo_mode,
    input  logic                       disp_valid,
    input  logic                       disp_tid,
    input  logic [TAG_W-1:0]           disp_old_tag,
    input  logic [TAG_W-1:0]           disp_new_tag,
    output logic                       disp_full,
    output logic [$clog2(DEPTH)-1:0]   disp_idx,
    input  logic                       cmp_valid,
    input  logic [$clog2(DEPTH)-1:0]   cmp_idx,
    input  logic [1:0]                 flush,
    output logic [1:0]                 cmt_valid,
    output logic [1:0][TAG_W-1:0]      cmt_old_tag,
    output logic [1:0][TAG_W-1:0]      cmt_new_tag
);
    import rob_pkg::*;

    localparam int IDX_W = $clog2(DEPTH);
    localparam int HALF  = DEPTH / 2;
    localparam logic [IDX_W:0] CAP_ALL  = (IDX_W+1)'(DEPTH);
    localparam logic [IDX_W:0] CAP_HALF = (IDX_W+1)'(HALF);

    thr_mask_t ring_full, ring_empty, thr_full, push, pop, head_hit, rd_done;
    logic [1:0][IDX_W-1:0] head_off, tail_off, head_idx, tail_idx;
    logic [1:0][IDX_W:0]   cap;

    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        localparam logic [IDX_W-1:0] BASE = IDX_W'(t * HALF);

        // Slice capacity and full flag; thread 1 gets nothing in solo mode.
        if (t == 0) begin : g_cap0
            assign cap[t]      = solo_mode ? CAP_ALL : CAP_HALF;
            assign thr_full[t] = ring_full[t];
        end else begin : g_cap1
            assign cap[t]      = solo_mode ? '0 : CAP_HALF;
            assign thr_full[t] = ring_full[t] | solo_mode;
        end

        // Map slice-local offsets onto global entry indices.
        assign head_idx[t] = BASE + head_off[t];
        assign tail_idx[t] = BASE + tail_off[t];

        // Retire the head if done already or completing right now.
        assign head_hit[t] = cmp_valid && (cmp_idx == head_idx[t]);
        assign pop[t]  = !ring_empty[t] && !flush[t] && (rd_done[t] || head_hit[t]);
        assign push[t] = disp_valid && (disp_tid == 1'(t)) && !flush[t] && !thr_full[t];

        rob_ring_ctrl #(.IDX_W(IDX_W)) i_ring (
            .clk      (clk),
            .rst_n    (rst_n),
            .cap      (cap[t]),
            .push     (push[t]),
            .pop      (pop[t]),
            .clear    (flush[t]),
            .head_off (head_off[t]),
            .tail_off (tail_off[t]),
            .full     (ring_full[t]),
            .empty    (ring_empty[t])
        );
    end

    // Dispatch response for the requesting thread.
    assign disp_full = thr_full[disp_tid];
    assign disp_idx  = tail_idx[disp_tid];

    rob_entry_store #(.DEPTH(DEPTH), .TAG_W(TAG_W), .IDX_W(IDX_W)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (|push),
        .wr_idx  (disp_idx),
        .wr_old  (disp_old_tag),
        .wr_new  (disp_new_tag),
        .cmp_en  (cmp_valid),
        .cmp_idx (cmp_idx),
        .rd_idx  (head_idx),
        .rd_done (rd_done),
        .rd_old  (cmt_old_tag),
        .rd_new  (cmt_new_tag)
    );

    // Retirement strobes per thread.
    assign cmt_valid = pop;

    assert_disp_in_slice_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_full && !solo_mode) |-> ((disp_idx >= IDX_W'(HALF)) == disp_tid));
    assert_solo_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        solo_mode |-> !cmt_valid[1]);
    assert_flush_no_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush[0] |-> !cmt_valid[0]);
endmodule

// File: tb/test_rob_partitioned.sv
`timescale 1ns/1ps
module test_rob_partitioned;
    localparam int DEPTH = 16;
    localparam int TAG_W = 6;
    localparam int IDX_W = 4;
    localparam int HALF  = DEPTH / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic solo_mode = 1'b0;
    logic disp_valid = 1'b0, disp_tid = 1'b0;
    logic [TAG_W-1:0] disp_old_tag = '0, disp_new_tag = '0;
    logic disp_full;
    logic [IDX_W-1:0] disp_idx;
    logic cmp_valid = 1'b0;
    logic [IDX_W-1:0] cmp_idx = '0;
    logic [1:0] flush = '0;
    logic [1:0] cmt_valid;
    logic [1:0][TAG_W-1:0] cmt_old_tag, cmt_new_tag;

    rob_partitioned #(.DEPTH(DEPTH), .TAG_W(TAG_W)) i_rob_partitioned (
        .clk(clk), .rst_n(rst_n), .solo_mode(solo_mode),
        .disp_valid(disp_valid), .disp_tid(disp_tid),
        .disp_old_tag(disp_old_tag), .disp_new_tag(disp_new_tag),
        .disp_full(disp_full), .disp_idx(disp_idx),
        .cmp_valid(cmp_valid), .cmp_idx(cmp_idx), .flush(flush),
        .cmt_valid(cmt_valid), .cmt_old_tag(cmt_old_tag), .cmt_new_tag(cmt_new_tag)
    );

    always #10 clk = ~clk;

    int total = 0, bad = 0, cyc = 0, tagctr = 1, t1_retired = 0;
    int fifo [2][DEPTH];
    int fcnt [2];
    int toff [2];
    bit m_done [DEPTH];
    int m_old [DEPTH];
    int m_new [DEPTH];
    logic [1:0] last_cv;
    logic last_full;
    int last_idx;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog R1 act=%0d exp=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int cap_of(int t);
        if (solo_mode) return (t == 0) ? DEPTH : 0;
        return HALF;
    endfunction

    function automatic int base_of(int t);
        return (t == 0) ? 0 : HALF;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, compare before posedge, update model after.
    task automatic step(input bit dv, input bit dt, input bit cv, input int cidx,
                        input bit [1:0] fl);
        bit exp_full;
        bit [1:0] exp_cv;
        int h, idx, dold, dnew;
        dold = tagctr % 64;
        dnew = (tagctr * 7 + 3) % 64;
        tagctr++;
        @(negedge clk);
        disp_valid = dv; disp_tid = dt;
        disp_old_tag = TAG_W'(dold); disp_new_tag = TAG_W'(dnew);
        cmp_valid = cv; cmp_idx = IDX_W'(cidx); flush = fl;
        #2;
        exp_full = (cap_of(dt) == 0) || (fcnt[dt] == cap_of(dt));
        last_full = disp_full;
        last_idx = int'(disp_idx);
        if (dv) begin
            check("R3 full", int'(disp_full), int'(exp_full));
            if (!exp_full) check("R2 index", int'(disp_idx), base_of(dt) + toff[dt]);
        end
        for (int t = 0; t < 2; t++) begin
            exp_cv[t] = 1'b0;
            h = 0;
            if (fcnt[t] > 0 && !fl[t]) begin
                h = fifo[t][0];
                exp_cv[t] = m_done[h] || (cv && cidx == h);
            end
            check("R4 retire", int'(cmt_valid[t]), int'(exp_cv[t]));
            if (exp_cv[t] && cmt_valid[t]) begin
                check("R7 old tag", int'(cmt_old_tag[t]), m_old[h]);
                check("R7 new tag", int'(cmt_new_tag[t]), m_new[h]);
            end
        end
        last_cv = cmt_valid;
        if (cmt_valid[1]) t1_retired++;
        @(posedge clk);
        for (int t = 0; t < 2; t++) begin
            if (fl[t]) begin
                fcnt[t] = 0; toff[t] = 0;
            end else if (exp_cv[t]) begin
                for (int k = 1; k < DEPTH; k++) fifo[t][k-1] = fifo[t][k];
                fcnt[t]--;
            end
        end
        if (cv) m_done[cidx] = 1'b1;
        if (dv && !exp_full && !fl[dt]) begin
            idx = base_of(dt) + toff[dt];
            m_done[idx] = 1'b0; m_old[idx] = dold; m_new[idx] = dnew;
            fifo[dt][fcnt[dt]] = idx;
            fcnt[dt]++;
            toff[dt] = (toff[dt] + 1 == cap_of(dt)) ? 0 : toff[dt] + 1;
        end
    endtask

    task automatic nop();
        step(0, 0, 0, 0, 2'b00);
    endtask

    task automatic rand_step(input int t1_weight);
        bit dv, dt, cv;
        int cidx, t;
        bit [1:0] fl;
        dv = ($urandom % 3) != 0;
        dt = ($urandom % 100) < t1_weight;
        cv = ($urandom % 4) != 0;
        t = $urandom % 2;
        if (fcnt[t] > 0 && ($urandom % 8) != 0) cidx = fifo[t][$urandom % fcnt[t]];
        else cidx = $urandom % DEPTH;
        fl[0] = ($urandom % 60) == 0;
        fl[1] = ($urandom % 60) == 0;
        step(dv, dt, cv, cidx, fl);
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int t = 0; t < 2; t++) begin fcnt[t] = 0; toff[t] = 0; end
        for (int i = 0; i < DEPTH; i++) begin m_done[i] = 0; m_old[i] = 0; m_new[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state
        #2;
        check("R1 no retire", int'(cmt_valid), 0);
        disp_tid = 1'b0; #1;
        check("R1 t0 not full", int'(disp_full), 0);
        check("R1 t0 first idx", int'(disp_idx), 0);
        disp_tid = 1'b1; #1;
        check("R1 t1 not full", int'(disp_full), 0);
        check("R1 t1 first idx", int'(disp_idx), HALF);

        // R5: same-cycle retire of a head
        step(1, 0, 0, 0, 2'b00);
        step(0, 0, 1, 0, 2'b00);
        check("R5 same-cycle retire", int'(last_cv[0]), 1);

        // R4: early completion waits for the older entry
        step(1, 0, 0, 0, 2'b00);            // idx 1
        step(1, 0, 0, 0, 2'b00);            // idx 2
        step(0, 0, 1, 2, 2'b00);
        check("R4 younger held", int'(last_cv[0]), 0);
        step(0, 0, 1, 1, 2'b00);
        check("R4 older retires", int'(last_cv[0]), 1);
        nop();
        check("R4 younger follows", int'(last_cv[0]), 1);

        // R6: stalled thread 1 head, thread 0 still retires
        step(1, 1, 0, 0, 2'b00);            // idx 8, left pending
        step(1, 0, 0, 0, 2'b00);            // idx 3
        step(0, 0, 1, 3, 2'b00);
        check("R6 t0 retires", int'(last_cv[0]), 1);
        check("R6 t1 held", int'(last_cv[1]), 0);

        // R3: fill thread 1, reject extra, thread 0 unaffected
        for (int i = 0; i < HALF - 1; i++) step(1, 1, 0, 0, 2'b00);
        step(1, 1, 0, 0, 2'b00);
        check("R3 t1 full", int'(last_full), 1);
        step(1, 0, 0, 0, 2'b00);            // idx 4, pending
        check("R3 t0 not full", int'(last_full), 0);
        t1_retired = 0;
        for (int i = 0; i < HALF; i++) step(0, 0, 1, HALF + i, 2'b00);
        repeat (2) nop();
        check("R3 rejected never retires", t1_retired, HALF);

        // R9: flush thread 1 only
        for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 2'b00);
        step(0, 0, 0, 0, 2'b10);
        step(0, 0, 1, 4, 2'b00);
        check("R9 other thread retires", int'(last_cv[0]), 1);
        step(1, 1, 0, 0, 2'b00);
        check("R9 t1 pointer reset", last_idx, HALF);

        // R10: completion to a free index is ignored
        step(0, 0, 0, 0, 2'b01);
        step(0, 0, 1, 0, 2'b00);
        step(1, 0, 0, 0, 2'b00);
        check("R9 t0 pointer reset", last_idx, 0);
        nop();
        check("R10 stale completion ignored", int'(last_cv[0]), 0);
        step(0, 0, 1, 0, 2'b00);
        check("R10 real completion retires", int'(last_cv[0]), 1);

        // R8: solo mode
        step(0, 0, 0, 0, 2'b11);
        solo_mode = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            step(1, 0, 0, 0, 2'b00);
            check("R8 solo index", last_idx, i);
        end
        step(1, 0, 0, 0, 2'b00);
        check("R8 t0 full at DEPTH", int'(last_full), 1);
        step(1, 1, 0, 0, 2'b00);
        check("R8 t1 always full", int'(last_full), 1);
        for (int i = DEPTH - 1; i > 0; i--) step(0, 0, 1, i, 2'b00);
        step(0, 0, 1, 0, 2'b00);
        check("R8 head retires", int'(last_cv[0]), 1);
        for (int i = 1; i < DEPTH; i++) begin
            nop();
            check("R7 one per cycle", int'(last_cv[0]), 1);
        end
        step(0, 0, 0, 0, 2'b11);
        solo_mode = 1'b0;

        // Random split-mode traffic
        for (int i = 0; i < 4000; i++) rand_step(50);
        step(0, 0, 0, 0, 2'b11);
        solo_mode = 1'b1;
        for (int i = 0; i < 1500; i++) rand_step(10);
        step(0, 0, 0, 0, 2'b11);
        solo_mode = 1'b0;
        nop();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule